// File: doc/BRIEF.md
# Audio Sample Buffer with Level Flags

This block holds 8-bit audio samples between a processor's register port and an audio output stage. Software writes samples one at a time into a data register. A programmable divider produces a consumption tick, and on each tick the oldest stored sample moves to the output. Three status flags describe how full the store is. A request flag says software should refill, an under-run flag says the store ran dry, and a busy flag says the store cannot take more. The request and under-run flags can raise an interrupt.

A source-enable bit in the control register switches the block on. While that bit is low, the store is held empty, the divider is idle, and no flag can be set. The request and under-run flags are cleared only by loading a sample; software writes to the status register have no effect. Both flags come out of reset set, so the block asks for data from the start.

When a tick arrives and the store is empty, the output keeps presenting the last sample it delivered.

Top module: `audio_sample_buffer`

## Requirements
- R1: After reset the status register (address 1) reads 0xC0, the data register (address 0) reads 0xFF, and the divider register (address 2) and the control register (address 3) read 0x00.
- R2: Register layout. Status is read only: bit 7 is request, bit 6 is under-run, bit 5 is busy, and bits 4..0 read 0. The divider register keeps bits 4..0, and bits 7..5 read 0. In the control register, bit 0 is source enable, bit 1 masks the request interrupt, and bit 2 masks the under-run interrupt. Reads are combinational from the read address.
- R3: A write to address 0 is accepted when source enable is 1 and the store is not full. Accepted samples leave in the order they were written, and the store holds at most 8. The data register reads back the last accepted sample.
- R4: While source enable is 1, a tick occurs once every divider value plus 1 clock cycles. Each tick drives `sampleStrobe` high for one cycle, in the cycle after the tick edge.
- R5: Busy reads 1 exactly when 8 samples are stored. A write to address 0 while busy changes neither the stored samples nor the data register readback.
- R6: The request flag is set when a tick removes a sample and leaves 4 of 8 entries occupied.
- R7: The under-run flag is set when a tick removes the last sample, or when a tick finds the store empty.
- R8: An accepted sample write clears both the request and under-run flags at the same edge. This clear takes priority over any set.
- R9: A tick on an empty store leaves `sampleOut` unchanged.
- R10: `irq` = `globalIntEn` AND ((request AND NOT request-mask) OR (under-run AND NOT under-run-mask)). It is combinational.
- R11: While source enable is 0, the store is emptied, the divider stays idle with no strobes, and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data, combinational |
| globalIntEn | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sampleOut | output | 8 | Current output sample |
| sampleStrobe | output | 1 | One-cycle pulse on each consumption tick |

## Verification
A register write takes effect at the edge on which `wrEn` is sampled, so status, readback and `irq` are checked at the falling edge right after that edge. A tick updates `sampleOut`, `sampleStrobe` and the flags at one edge. The bench waits for the strobe at falling edges, then reads the status in that same half cycle. It counts falling edges between strobes and compares the count with the divider value plus 1. It also checks the falling edge right after a write, where a divider value of 0 makes the first delivery due one cycle after the write.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  localparam int REGW = 8;
  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_CLKDIV = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  typedef struct packed {
    logic push;
    logic pop;
    logic tick;
    logic flush;
  } abufStrobes_t;
endpackage

// File: rtl/abuf_datapath.sv
module abuf_datapath
  import abuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  abufStrobes_t     strobes,
  input  logic [WIDTH-1:0] pushData,
  output logic [CW-1:0]    count,
  output logic [WIDTH-1:0] sampleOut,
  output logic             sampleStrobe
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut    <= '0;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= strobes.tick;
      if (strobes.pop) sampleOut <= mem[rdPtr];
    end
  end
endmodule

// File: rtl/abuf_ctrl.sv
module abuf_ctrl
  import abuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIVW  = 5,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [REGW-1:0] wrData,
  input  logic [1:0]      rdAddr,
  input  logic [CW-1:0]   count,
  input  logic            globalIntEn,
  output abufStrobes_t    strobes,
  output logic [REGW-1:0] rdData,
  output logic            irq,
  output logic            srcEn,
  output logic            busy,
  output logic            reqFlag,
  output logic            udrnFlag
);
  logic [DIVW-1:0] divVal, divCnt;
  logic [REGW-1:0] lastSample;
  logic reqMask, udrnMask;
  logic empty, tick, push, pop, fallsToHalf, runsDry;

  assign busy  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign tick  = srcEn && (divCnt == divVal);
  assign push  = wrEn && (wrAddr == ADDR_DATA) && srcEn && !busy;
  assign pop   = tick && !empty;

  assign strobes = '{push: push, pop: pop, tick: tick, flush: !srcEn};

  assign fallsToHalf = pop && (count == CW'(HALF + 1));
  assign runsDry     = (pop && (count == CW'(1))) || (tick && empty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal     <= '0;
      srcEn      <= 1'b0;
      reqMask    <= 1'b0;
      udrnMask   <= 1'b0;
      lastSample <= '1;
    end else begin
      if (push) lastSample <= wrData;
      if (wrEn && wrAddr == ADDR_CLKDIV) divVal <= wrData[DIVW-1:0];
      if (wrEn && wrAddr == ADDR_CTRL) begin
        srcEn    <= wrData[0];
        reqMask  <= wrData[1];
        udrnMask <= wrData[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divCnt <= '0;
    else if (!srcEn) divCnt <= '0;
    else if (tick)   divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqFlag  <= 1'b1;
      udrnFlag <= 1'b1;
    end else if (push) begin
      reqFlag  <= 1'b0;
      udrnFlag <= 1'b0;
    end else begin
      if (fallsToHalf) reqFlag  <= 1'b1;
      if (runsDry)     udrnFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_DATA:   rdData = lastSample;
      ADDR_STATUS: rdData = {reqFlag, udrnFlag, busy, 5'b0};
      ADDR_CLKDIV: rdData = REGW'(divVal);
      default:     rdData = {5'b0, udrnMask, reqMask, srcEn};
    endcase
  end

  assign irq = globalIntEn && ((reqFlag && !reqMask) || (udrnFlag && !udrnMask));
endmodule

// File: rtl/audio_sample_buffer.sv
module audio_sample_buffer
  import abuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIVW  = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       globalIntEn,
  output logic       irq,
  output logic [7:0] sampleOut,
  output logic       sampleStrobe
);
  abufStrobes_t strobes;
  logic [CW-1:0] count;
  logic srcEn, busy, reqFlag, udrnFlag;

  abuf_ctrl #(.DEPTH(DEPTH), .DIVW(DIVW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .count(count), .globalIntEn(globalIntEn),
    .strobes(strobes), .rdData(rdData), .irq(irq), .srcEn(srcEn),
    .busy(busy), .reqFlag(reqFlag), .udrnFlag(udrnFlag)
  );

  abuf_datapath #(.DEPTH(DEPTH), .WIDTH(REGW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushData(wrData),
    .count(count), .sampleOut(sampleOut), .sampleStrobe(sampleStrobe)
  );
endmodule

// File: rtl/abuf_checker.sv
module abuf_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [1:0]    wrAddr,
  input logic          globalIntEn,
  input logic          irq,
  input logic [7:0]    sampleOut,
  input logic [CW-1:0] count,
  input logic          srcEn,
  input logic          busy,
  input logic          reqFlag,
  input logic          udrnFlag,
  input logic          tick,
  input logic          pop
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  p_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0 && busy && !pop) |=> (count == $past(count)));

  p_req_at_half_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqFlag) |-> ($past(count) == CW'(DEPTH / 2 + 1)));

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0 && srcEn && !busy) |=> (!reqFlag && !udrnFlag));

  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == '0) |=> $stable(sampleOut));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !globalIntEn |-> !irq);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    !srcEn |=> (count == '0));
endmodule

bind audio_sample_buffer abuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .globalIntEn(globalIntEn), .irq(irq), .sampleOut(sampleOut),
  .count(count), .srcEn(srcEn), .busy(busy), .reqFlag(reqFlag),
  .udrnFlag(udrnFlag), .tick(strobes.tick), .pop(strobes.pop)
);

// File: tb/audio_sample_buffer_bench.sv
`timescale 1ns/1ps
module audio_sample_buffer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic globalIntEn = 1'b1;
  logic irq;
  logic [7:0] sampleOut;
  logic sampleStrobe;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  audio_sample_buffer u_audio_sample_buffer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .globalIntEn(globalIntEn), .irq(irq),
    .sampleOut(sampleOut), .sampleStrobe(sampleStrobe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic waitStrobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleStrobe && n < 200);
  endtask

  task automatic tResetState();
    logic [7:0] v;
    rd(2'd1, v); chk("R1 status", v, 8'hC0);
    rd(2'd0, v); chk("R1 data", v, 8'hFF);
    rd(2'd2, v); chk("R1 divider", v, 8'h00);
    rd(2'd3, v); chk("R1 control", v, 8'h00);
    chk("R10 irq at reset", {7'b0, irq}, 8'h01);
    chk("R11 no strobe while disabled", {7'b0, sampleStrobe}, 8'h00);
  endtask

  task automatic tRegisters();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R2 divider upper bits", v, 8'h1F);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R2 status read only", v, 8'hC0);
    wr(2'd3, 8'h06);
    rd(2'd3, v); chk("R2 control readback", v, 8'h06);
    chk("R10 both masked", {7'b0, irq}, 8'h00);
    wr(2'd3, 8'h02);
    chk("R10 udrn unmasked", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'h00);
  endtask

  task automatic tFillDrain();
    logic [7:0] v;
    int n;
    wr(2'd2, 8'd31);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h11);
    rd(2'd1, v); chk("R8 flags cleared by load", v, 8'h00);
    chk("R10 irq low after load", {7'b0, irq}, 8'h00);
    for (int i = 1; i < 8; i++) wr(2'd0, 8'(8'h11 * (i + 1)));
    rd(2'd1, v); chk("R5 busy when full", v, 8'h20);
    wr(2'd0, 8'hEE);
    rd(2'd0, v); chk("R5 write while busy ignored", v, 8'h88);
    for (int k = 0; k < 8; k++) begin
      waitStrobe(n);
      if (k > 0) chk("R4 strobe interval div 31", 8'(n), 8'd32);
      chk("R3 output order", sampleOut, 8'(8'h11 * (k + 1)));
      rd(2'd1, v);
      if (k == 0) chk("R5 busy clears", {7'b0, v[5]}, 8'h00);
      if (k < 7) chk("R6 request level", {7'b0, v[7]}, (k >= 3) ? 8'h01 : 8'h00);
      if (k == 3) chk("R10 irq on request", {7'b0, irq}, 8'h01);
      if (k == 6) chk("R7 no under-run yet", {7'b0, v[6]}, 8'h00);
      if (k == 7) chk("R7 under-run on last", {7'b0, v[6]}, 8'h01);
    end
    waitStrobe(n);
    chk("R9 repeat last sample", sampleOut, 8'h88);
    chk("R4 interval on empty", 8'(n), 8'd32);
  endtask

  task automatic tFastDivider();
    logic [7:0] v;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h5A);
    rd(2'd1, v); chk("R8 load beats empty tick", {6'b0, v[7:6]}, 8'h00);
    @(negedge clk);
    chk("R4 div 0 delivers next cycle", sampleOut, 8'h5A);
    chk("R4 strobe div 0", {7'b0, sampleStrobe}, 8'h01);
    rd(2'd1, v); chk("R7 under-run after drain", {7'b0, v[6]}, 8'h01);
    @(negedge clk);
    chk("R4 strobe every cycle", {7'b0, sampleStrobe}, 8'h01);
    chk("R9 hold on empty", sampleOut, 8'h5A);
  endtask

  task automatic tFlush();
    logic [7:0] v;
    int n;
    int strobes;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'd31);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h03);
    wr(2'd3, 8'h00);
    strobes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sampleStrobe) strobes++;
    end
    chk("R11 no strobes while disabled", 8'(strobes), 8'd0);
    rd(2'd1, v); chk("R11 no flags while disabled", v, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h77);
    waitStrobe(n);
    chk("R11 old samples flushed", sampleOut, 8'h77);
    chk("R10 irq on under-run", {7'b0, irq}, 8'h01);
    globalIntEn = 1'b0;
    #0.5;
    chk("R10 global enable off", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tRegisters();
    tFillDrain();
    tFastDivider();
    tFlush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule